// File: doc/BRIEF.md
# Condition-Field Three-Input Logic Unit

This block holds a small file of eight 4-bit condition fields and applies a programmable three-input bitwise function to them. A request names a destination field and two source fields. It also carries an 8-bit truth table and a 4-bit write mask. For every bit position the unit combines the destination bit and the two source bits into a 3-bit index. The truth-table bit at that index becomes the new bit, but only where the mask allows it. Where the mask does not allow it, the old destination bit stays.

The merged value is written back into the destination field on the clock edge that accepts the request. The same value appears on a result output next to a one-cycle done pulse. A new request can be accepted on every cycle. A separate read port lets the surrounding logic or a bench look at any field.

Top module: `cond_tern_unit`

## Requirements
- R1: A synchronous active-high reset clears all eight fields to 0000 and holds `doneOut` low.
- R2: For each bit position i, the lookup index is {destination bit i, source A bit i, source B bit i}, with the destination bit as the most significant bit (index bit 2) and source B as the least significant bit (index bit 0). Where mask bit i is 1, result bit i is `truthImm[index]`.
- R3: Where mask bit i is 0, result bit i equals the destination field's bit i as it stood before the operation.
- R4: The result is written into the destination field. The source fields and every other field keep their values.
- R5: When a source selector names the destination field, every input bit is read from that field's value before the operation.
- R6: `doneOut` is high for exactly the cycle after each accepted request, and low after any cycle without a request. While `doneOut` is high, `resultOut` holds the value that was written.
- R7: Requests on consecutive cycles are all accepted. A request sees the fields as left by the request of the cycle before it.
- R8: `peekData` shows the field named by `peekSel`. It shows a write from the edge at which that write happens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reqValid | input | 1 | Request strobe, one operation per cycle |
| dstSel | input | 3 | Destination field selector (also third lookup input) |
| srcASel | input | 3 | Source A field selector (lookup index bit 1) |
| srcBSel | input | 3 | Source B field selector (lookup index bit 0) |
| truthImm | input | 8 | Truth table, bit k is the output for index k |
| bitMask | input | 4 | Per-bit write enable for the merge |
| doneOut | output | 1 | One-cycle completion pulse |
| resultOut | output | 4 | Value written by the last completed request |
| peekSel | input | 3 | Read-port field selector |
| peekData | output | 4 | Read-port field contents |

## Verification
A corrupted field shows up in two ways. It appears on the read port from the cycle after it goes wrong. It also feeds every later lookup that names it, so a wrong bit spreads into results one cycle after the next request uses it. A wrong index order or a wrong merge gives a wrong `resultOut` in the very cycle of the done pulse. A slip in the control pipeline shows as a done pulse that comes early, comes late or is missing. The bench keeps its own model of all eight fields. Each cycle it compares the done flag, the result and one read-port field, rotating through the fields, so a stray write is caught within eight cycles at most.

// File: rtl/ctu_pkg.sv
package ctu_pkg;

  // Strobes from the control module to the datapath.
  typedef struct packed {
    logic writeEn;
    logic captureResult;
  } ctuStrobes_t;

endpackage

// File: rtl/ctu_control.sv
module ctu_control
  import ctu_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        reqValid,
  output ctuStrobes_t strobes,
  output logic        doneOut
);

  logic doneQ;

  always_comb begin
    strobes.writeEn       = reqValid & ~rst;
    strobes.captureResult = reqValid & ~rst;
  end

  always_ff @(posedge clk) begin
    if (rst) doneQ <= 1'b0;
    else     doneQ <= reqValid;
  end

  assign doneOut = doneQ;

endmodule

// File: rtl/ctu_datapath.sv
module ctu_datapath
  import ctu_pkg::*;
#(
  parameter int FIELD_W    = 4,
  parameter int NUM_FIELDS = 8,
  parameter int SEL_W      = $clog2(NUM_FIELDS),
  parameter int LUT_IN     = 3,
  parameter int IMM_W      = 1 << LUT_IN
) (
  input  logic               clk,
  input  logic               rst,
  input  ctuStrobes_t        strobes,
  input  logic [SEL_W-1:0]   dstSel,
  input  logic [SEL_W-1:0]   srcASel,
  input  logic [SEL_W-1:0]   srcBSel,
  input  logic [IMM_W-1:0]   truthImm,
  input  logic [FIELD_W-1:0] bitMask,
  input  logic [SEL_W-1:0]   peekSel,
  output logic [FIELD_W-1:0] peekData,
  output logic [FIELD_W-1:0] dstRead,
  output logic [FIELD_W-1:0] resultOut
);

  logic [FIELD_W-1:0] fieldMem [NUM_FIELDS];
  logic [FIELD_W-1:0] srcARead;
  logic [FIELD_W-1:0] srcBRead;
  logic [FIELD_W-1:0] merged;
  logic [FIELD_W-1:0] resultQ;

  // All reads use the pre-operation contents of the file.
  always_comb begin
    dstRead  = fieldMem[dstSel];
    srcARead = fieldMem[srcASel];
    srcBRead = fieldMem[srcBSel];
    peekData = fieldMem[peekSel];
  end

  // One lookup slice per bit position.
  for (genvar i = 0; i < FIELD_W; i++) begin : g_bit
    logic [LUT_IN-1:0] lutIdx;
    logic              lutBit;
    always_comb begin
      lutIdx    = {dstRead[i], srcARead[i], srcBRead[i]};
      lutBit    = truthImm[lutIdx];
      merged[i] = bitMask[i] ? lutBit : dstRead[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int f = 0; f < NUM_FIELDS; f++) fieldMem[f] <= '0;
    end else if (strobes.writeEn) begin
      fieldMem[dstSel] <= merged;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                        resultQ <= '0;
    else if (strobes.captureResult) resultQ <= merged;
  end

  assign resultOut = resultQ;

endmodule

// File: rtl/cond_tern_unit.sv
module cond_tern_unit
  import ctu_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       reqValid,
  input  logic [2:0] dstSel,
  input  logic [2:0] srcASel,
  input  logic [2:0] srcBSel,
  input  logic [7:0] truthImm,
  input  logic [3:0] bitMask,
  output logic       doneOut,
  output logic [3:0] resultOut,
  input  logic [2:0] peekSel,
  output logic [3:0] peekData
);

  ctuStrobes_t strobes;
  logic [3:0]  dstRead;

  ctu_control u_control (
    .clk      (clk),
    .rst      (rst),
    .reqValid (reqValid),
    .strobes  (strobes),
    .doneOut  (doneOut)
  );

  ctu_datapath #(
    .FIELD_W    (4),
    .NUM_FIELDS (8)
  ) u_datapath (
    .clk       (clk),
    .rst       (rst),
    .strobes   (strobes),
    .dstSel    (dstSel),
    .srcASel   (srcASel),
    .srcBSel   (srcBSel),
    .truthImm  (truthImm),
    .bitMask   (bitMask),
    .peekSel   (peekSel),
    .peekData  (peekData),
    .dstRead   (dstRead),
    .resultOut (resultOut)
  );

endmodule

// File: rtl/ctu_checker.sv
module ctu_checker (
  input logic       clk,
  input logic       rst,
  input logic       reqValid,
  input logic [2:0] dstSel,
  input logic [7:0] truthImm,
  input logic [3:0] bitMask,
  input logic       doneOut,
  input logic [3:0] resultOut,
  input logic [2:0] peekSel,
  input logic [3:0] peekData,
  input logic [3:0] dstRead
);

  // R1: first cycle out of reset shows no completion
  a_r1_reset_quiet: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !doneOut);

  // R6: a request completes on the next cycle
  a_r6_done_follows: assert property (@(posedge clk) disable iff (rst)
    reqValid |=> doneOut);

  // R6: no request, no completion
  a_r6_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !reqValid |=> !doneOut);

  // R3: unmasked bits keep the old destination value
  a_r3_masked_keep: assert property (@(posedge clk) disable iff (rst)
    reqValid |=> (((resultOut ^ $past(dstRead)) & ~$past(bitMask)) == 4'h0));

  // R2: an all-ones table under a full mask yields all ones
  a_r2_all_ones: assert property (@(posedge clk) disable iff (rst)
    (reqValid && bitMask == 4'hF && truthImm == 8'hFF) |=> resultOut == 4'hF);

  // R8: the read port shows the field just written
  a_r8_peek_written: assert property (@(posedge clk) disable iff (rst)
    (doneOut && peekSel == $past(dstSel)) |-> peekData == resultOut);

endmodule

bind cond_tern_unit ctu_checker u_ctu_checker (
  .clk       (clk),
  .rst       (rst),
  .reqValid  (reqValid),
  .dstSel    (dstSel),
  .truthImm  (truthImm),
  .bitMask   (bitMask),
  .doneOut   (doneOut),
  .resultOut (resultOut),
  .peekSel   (peekSel),
  .peekData  (peekData),
  .dstRead   (dstRead)
);

// File: tb/cond_tern_unit_test.sv
module cond_tern_unit_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       reqValid = 1'b0;
  logic [2:0] dstSel = '0;
  logic [2:0] srcASel = '0;
  logic [2:0] srcBSel = '0;
  logic [7:0] truthImm = '0;
  logic [3:0] bitMask = '0;
  logic [2:0] peekSel = '0;
  logic       doneOut;
  logic [3:0] resultOut;
  logic [3:0] peekData;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  string curTag = "R2";

  int model [8];
  int expDone = 0;
  int expRes  = 0;
  string chkTag;

  always #10 clk = ~clk;

  cond_tern_unit uut (
    .clk(clk), .rst(rst), .reqValid(reqValid),
    .dstSel(dstSel), .srcASel(srcASel), .srcBSel(srcBSel),
    .truthImm(truthImm), .bitMask(bitMask),
    .doneOut(doneOut), .resultOut(resultOut),
    .peekSel(peekSel), .peekData(peekData)
  );

  function automatic int refOp(int d, int a, int b, int imm, int msk);
    int r;
    r = d;
    for (int i = 0; i < 4; i++) begin
      int idx;
      idx = 0;
      if ((d >> i) & 1) idx += 4;
      if ((a >> i) & 1) idx += 2;
      if ((b >> i) & 1) idx += 1;
      if ((msk >> i) & 1) begin
        if ((imm >> idx) & 1) r = r | (1 << i);
        else                  r = r & ~(1 << i);
      end
    end
    return r;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Reference model advances on each edge, then compares a quarter period later.
  always @(posedge clk) begin
    if (rst) begin
      for (int f = 0; f < 8; f++) model[f] = 0;
      expDone = 0;
      expRes  = 0;
    end else if (reqValid) begin
      expRes  = refOp(model[dstSel], model[srcASel], model[srcBSel], truthImm, bitMask);
      model[dstSel] = expRes;
      expDone = 1;
    end else begin
      expDone = 0;
    end
    chkTag = curTag;
    #5;
    if (!rst) begin
      check("R6 done", doneOut, expDone);
      if (expDone == 1) check({chkTag, " result"}, resultOut, expRes);
      check("R4 R8 peek", peekData, model[peekSel]);
    end
  end

  always @(negedge clk) begin
    peekSel = peekSel + 3'd1;
    cycles++;
  end

  task automatic op(input int d, input int a, input int b, input int imm, input int msk,
                    input string tag);
    @(negedge clk);
    reqValid = 1'b1;
    dstSel = d[2:0]; srcASel = a[2:0]; srcBSel = b[2:0];
    truthImm = imm[7:0]; bitMask = msk[3:0];
    curTag = tag;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      reqValid = 1'b0;
    end
  endtask

  task automatic setField(input int f, input int v);
    op(f, 0, 0, 8'hFF, v, "R3");
    op(f, 0, 0, 8'h00, (~v) & 4'hF, "R3");
  endtask

  initial begin
    int seed;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 done after reset", doneOut, 0);
    for (int f = 0; f < 8; f++) begin
      peekSel = f[2:0];
      #1 check("R1 field cleared", peekData, 0);
    end
    setField(1, 4'hC);
    setField(2, 4'hA);
    setField(3, 4'h6);
    idle(2);
    op(3, 1, 2, 8'h96, 4'hF, "R2");   // three-way parity
    op(4, 1, 2, 8'hF0, 4'hF, "R2");   // copies destination
    op(5, 1, 2, 8'hCC, 4'hF, "R2");   // copies source A
    op(6, 1, 2, 8'hAA, 4'hF, "R2");   // copies source B
    idle(1);
    op(3, 1, 2, 8'hE8, 4'h5, "R3");   // majority, partial mask
    op(3, 1, 2, 8'h00, 4'h0, "R3");   // mask zero: no change
    idle(1);
    op(2, 2, 2, 8'h0F, 4'hF, "R5");   // all selectors alias: invert
    op(1, 1, 7, 8'h3C, 4'hF, "R5");   // source A aliases destination
    idle(1);
    op(7, 1, 2, 8'hFF, 4'hF, "R7");
    op(0, 7, 7, 8'hCC, 4'hF, "R7");   // uses value written a cycle before
    op(7, 0, 1, 8'h66, 4'hB, "R7");
    idle(2);
    seed = 12345;
    for (int n = 0; n < 60; n++) begin
      seed = seed * 1103515245 + 12345;
      op((seed >> 8) & 7, (seed >> 12) & 7, (seed >> 16) & 7,
         (seed >> 20) & 8'hFF, (seed >> 4) & 4'hF, "R2 R3");
      if (((seed >> 28) & 3) == 0) idle(1);
    end
    idle(10);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait (cycles > 5000);
    errors++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule